// File: doc/BRIEF.md
# External-Port DMA Channel Controller

This block runs one DMA channel on an external memory port. A three-bit mode field selects how the channel works. It chooses which pin groups the channel uses: the address bus with read and write strobes, the request input with the grant output, or both. It also chooses who starts each transfer, the channel itself or the device outside. The channel keeps an index, a signed step (the modifier) and a transfer count. After each completed transfer it adds the modifier to the index and lowers the count by one. When the count runs out, the channel stops and raises a done interrupt for one cycle.

A load pulse programs the channel. The pulse writes the mode, the direction, the start index, the modifier and the count all at once, and the channel starts on the next cycle. A load that arrives while a sequence is running replaces that sequence. A transfer on the bus completes on a cycle in which a strobe is low and the acknowledge input is high. The request input is asynchronous and passes through two flops before the channel uses it.

Top module: `ext_dma_channel`

## Requirements
- R1: The mode code is read as bits {master, handshake, extern}. The codes are 000 slave, 010 handshake, 011 external handshake, 100 master and 110 paced master. A load with code 001, 101 or 111 starts nothing and leaves the channel not busy. It also sets `cfg_err_o`, which stays high until reset, including through later legal loads.
- R2: In master mode the channel holds a strobe low from the cycle after the load. `addr_o` carries the current index whenever a strobe is low and reads zero otherwise. Every cycle with `ack_i` high completes one transfer, so back-to-back transfers take one cycle each. `grant_n_o` stays high.
- R3: A direction of 1 (internal to outward) uses `wr_n_o`. A direction of 0 (outside to internal) uses `rd_n_o`. The two strobes are never low together.
- R4: In paced master mode no strobe goes low while the synchronized request is inactive. Each transfer waits for an active request level and then completes on `ack_i`. `grant_n_o` stays high.
- R5: In handshake mode each falling edge of `req_n_i`, after two synchronizing flops, gets one grant. The grant holds `grant_n_o` low for exactly one cycle, and that grant is the transfer. The strobes stay high and the address stays zero.
- R6: In external handshake mode each accepted request first gives a one-cycle grant. After that the strobe and address are driven until `ack_i` completes the transfer.
- R7: In slave mode the channel never drives a strobe or a grant. Each cycle with `slave_acc_i` high counts as one transfer.
- R8: Each completed transfer adds the modifier to the index modulo 2^AW and lowers the count by one. Bus addresses therefore run index, index+mod, index+2·mod, and so on.
- R9: After the final transfer, `done_irq_o` is high for exactly one cycle and `busy_o` goes low. A load with a count of zero starts nothing and gives no done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load_i | input | 1 | Load pulse that programs and starts the channel |
| cfg_mode_i | input | 3 | Mode code {master, handshake, extern} |
| cfg_dir_i | input | 1 | 1: internal to outward (write), 0: outside to internal (read) |
| cfg_index_i | input | AW | Start index |
| cfg_modify_i | input | AW | Step added per transfer (two's complement) |
| cfg_count_i | input | CW | Number of transfers |
| req_n_i | input | 1 | Asynchronous active-low transfer request |
| ack_i | input | 1 | Completes the current bus transfer |
| slave_acc_i | input | 1 | One external access in slave mode |
| addr_o | output | AW | Address during a strobe, else zero |
| rd_n_o | output | 1 | Active-low read strobe |
| wr_n_o | output | 1 | Active-low write strobe |
| grant_n_o | output | 1 | Active-low grant |
| busy_o | output | 1 | Sequence in progress |
| done_irq_o | output | 1 | One-cycle completion interrupt |
| cfg_err_o | output | 1 | Sticky reserved-mode flag |

## Verification
Two situations are the hardest to reach from the ports. The first is a paced master channel left armed with no request, where it must show no strobe activity at all. The second is the external handshake order, where the grant and the strobe must come in separate cycles. The stimulus holds the request inactive for several cycles after a paced load before it lets the request through. It drives each handshake request as an isolated low pulse that lasts longer than the synchronizer delay, so that exactly one edge is seen. The scoreboard expects the grant item before the bus item for each external handshake transfer, and it flags a grant that stays low for two samples.

// File: rtl/ext_dma_pkg.sv
package ext_dma_pkg;

  localparam logic [2:0] MODE_SLAVE = 3'b000;
  localparam logic [2:0] MODE_HSK   = 3'b010;
  localparam logic [2:0] MODE_XHSK  = 3'b011;
  localparam logic [2:0] MODE_MAST  = 3'b100;
  localparam logic [2:0] MODE_PACE  = 3'b110;

  typedef struct packed {
    logic legal;
    logic slave;
    logic master;
    logic paced;
    logic hsk;
    logic xhsk;
  } mode_dec_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_GNT  = 2'd2,
    ST_BUS  = 2'd3
  } seq_st_e;

endpackage

// File: rtl/ext_dma_mode_dec.sv
module ext_dma_mode_dec
  import ext_dma_pkg::*;
(
  input  logic [2:0] mode_bits_i,
  output mode_dec_t  dec_o
);

  always_comb begin
    dec_o = '0;
    unique case (mode_bits_i)
      MODE_SLAVE: begin dec_o.legal = 1'b1; dec_o.slave  = 1'b1; end
      MODE_HSK:   begin dec_o.legal = 1'b1; dec_o.hsk    = 1'b1; end
      MODE_XHSK:  begin dec_o.legal = 1'b1; dec_o.xhsk   = 1'b1; end
      MODE_MAST:  begin dec_o.legal = 1'b1; dec_o.master = 1'b1; end
      MODE_PACE:  begin dec_o.legal = 1'b1; dec_o.paced  = 1'b1; end
      default:    dec_o = '0;
    endcase
  end

endmodule

// File: rtl/ext_dma_req_sync.sv
module ext_dma_req_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_n_i,
  output logic req_lvl_o,
  output logic req_rise_o
);

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   lvl_dly_q;

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], ~req_n_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q    <= '0;
      lvl_dly_q <= 1'b0;
    end else begin
      sync_q    <= sync_d;
      lvl_dly_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign req_lvl_o  = sync_q[SYNC_STAGES-1];
  assign req_rise_o = sync_q[SYNC_STAGES-1] & ~lvl_dly_q;

endmodule

// File: rtl/ext_dma_addr_gen.sv
module ext_dma_addr_gen #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [AW-1:0] ld_index_i,
  input  logic [AW-1:0] ld_mod_i,
  input  logic [CW-1:0] ld_count_i,
  input  logic          step_i,
  output logic [AW-1:0] index_o,
  output logic          last_o
);

  logic [AW-1:0] idx_q, idx_d, mod_q, mod_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          upd_en;

  assign upd_en = load_i | step_i;

  always_comb begin
    idx_d = idx_q;
    mod_d = mod_q;
    cnt_d = cnt_q;
    if (load_i) begin
      idx_d = ld_index_i;
      mod_d = ld_mod_i;
      cnt_d = ld_count_i;
    end else if (step_i) begin
      idx_d = idx_q + mod_q;
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      mod_q <= '0;
      cnt_q <= '0;
    end else if (upd_en) begin
      idx_q <= idx_d;
      mod_q <= mod_d;
      cnt_q <= cnt_d;
    end
  end

  assign index_o = idx_q;
  assign last_o  = (cnt_q == {{(CW-1){1'b0}}, 1'b1});

  AST_STEP_ARITH: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i) |=> (cnt_q == $past(cnt_q) - 1'b1) &&
                            (idx_q == $past(idx_q) + $past(mod_q))); // R8

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |-> (cnt_q != '0)); // R9

endmodule

// File: rtl/ext_dma_seq.sv
module ext_dma_seq
  import ext_dma_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      load_i,
  input  mode_dec_t ld_dec_i,
  input  logic      ld_dir_i,
  input  logic      ld_cnt_zero_i,
  input  logic      req_lvl_i,
  input  logic      req_rise_i,
  input  logic      ack_i,
  input  logic      slave_acc_i,
  input  logic      last_i,
  output logic      step_o,
  output logic      bus_act_o,
  output logic      rd_n_o,
  output logic      wr_n_o,
  output logic      grant_n_o,
  output logic      busy_o,
  output logic      done_o,
  output logic      cfg_err_o
);

  seq_st_e   st_q, st_d;
  mode_dec_t mode_q, mode_d;
  logic      dir_q, dir_d;
  logic      err_q, err_d;
  logic      done_q, done_d;
  logic      step;

  always_comb begin
    st_d   = st_q;
    mode_d = mode_q;
    dir_d  = dir_q;
    err_d  = err_q;
    done_d = 1'b0;
    step   = 1'b0;
    if (load_i) begin
      mode_d = ld_dec_i;
      dir_d  = ld_dir_i;
      if (!ld_dec_i.legal) begin
        err_d = 1'b1;
        st_d  = ST_IDLE;
      end else if (ld_cnt_zero_i) begin
        st_d  = ST_IDLE;
      end else if (ld_dec_i.master) begin
        st_d  = ST_BUS;
      end else begin
        st_d  = ST_WAIT;
      end
    end else begin
      unique case (st_q)
        ST_WAIT: begin
          if (mode_q.slave) begin
            if (slave_acc_i) begin
              step = 1'b1;
              if (last_i) begin
                st_d   = ST_IDLE;
                done_d = 1'b1;
              end
            end
          end else if (mode_q.paced) begin
            if (req_lvl_i) st_d = ST_BUS;
          end else if (mode_q.hsk || mode_q.xhsk) begin
            if (req_rise_i) st_d = ST_GNT;
          end
        end
        ST_GNT: begin
          if (mode_q.hsk) begin
            step   = 1'b1;
            done_d = last_i;
            st_d   = last_i ? ST_IDLE : ST_WAIT;
          end else begin
            st_d = ST_BUS;
          end
        end
        ST_BUS: begin
          if (ack_i) begin
            step = 1'b1;
            if (last_i) begin
              st_d   = ST_IDLE;
              done_d = 1'b1;
            end else begin
              st_d = mode_q.master ? ST_BUS : ST_WAIT;
            end
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      mode_q <= '0;
      dir_q  <= 1'b0;
      err_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      err_q  <= err_d;
      if (load_i) begin
        mode_q <= mode_d;
        dir_q  <= dir_d;
      end
    end
  end

  assign step_o    = step;
  assign bus_act_o = (st_q == ST_BUS);
  assign rd_n_o    = ~(bus_act_o & ~dir_q);
  assign wr_n_o    = ~(bus_act_o &  dir_q);
  assign grant_n_o = ~(st_q == ST_GNT);
  assign busy_o    = (st_q != ST_IDLE);
  assign done_o    = done_q;
  assign cfg_err_o = err_q;

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err_o |=> cfg_err_o); // R1

  AST_RSV_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !ld_dec_i.legal) |=> !busy_o); // R1

  AST_MASTER_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q.master || mode_q.paced) |-> grant_n_o); // R2

  AST_PACE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q.paced && st_q == ST_WAIT && !req_lvl_i && !load_i) |=> (rd_n_o && wr_n_o)); // R4

  AST_GRANT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!grant_n_o && !load_i) |=> grant_n_o); // R5

  AST_QUIET_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q.slave || mode_q.hsk) |-> (rd_n_o && wr_n_o)); // R7

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R9

endmodule

// File: rtl/ext_dma_channel.sv
module ext_dma_channel
  import ext_dma_pkg::*;
#(
  parameter int AW          = 16,
  parameter int CW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_load_i,
  input  logic [2:0]    cfg_mode_i,
  input  logic          cfg_dir_i,
  input  logic [AW-1:0] cfg_index_i,
  input  logic [AW-1:0] cfg_modify_i,
  input  logic [CW-1:0] cfg_count_i,
  input  logic          req_n_i,
  input  logic          ack_i,
  input  logic          slave_acc_i,
  output logic [AW-1:0] addr_o,
  output logic          rd_n_o,
  output logic          wr_n_o,
  output logic          grant_n_o,
  output logic          busy_o,
  output logic          done_irq_o,
  output logic          cfg_err_o
);

  logic [1:0]    rst_sync_q;
  logic          rst_sn;
  mode_dec_t     ld_dec;
  logic          req_lvl, req_rise;
  logic          step, last, bus_act;
  logic [AW-1:0] index;
  logic          cnt_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sn = rst_sync_q[1];

  assign cnt_zero = (cfg_count_i == '0);

  ext_dma_mode_dec u_dec (
    .mode_bits_i (cfg_mode_i),
    .dec_o       (ld_dec)
  );

  ext_dma_req_sync #(.SYNC_STAGES(SYNC_STAGES)) u_req (
    .clk        (clk),
    .rst_n      (rst_sn),
    .req_n_i    (req_n_i),
    .req_lvl_o  (req_lvl),
    .req_rise_o (req_rise)
  );

  ext_dma_addr_gen #(.AW(AW), .CW(CW)) u_addr (
    .clk        (clk),
    .rst_n      (rst_sn),
    .load_i     (cfg_load_i),
    .ld_index_i (cfg_index_i),
    .ld_mod_i   (cfg_modify_i),
    .ld_count_i (cfg_count_i),
    .step_i     (step),
    .index_o    (index),
    .last_o     (last)
  );

  ext_dma_seq u_seq (
    .clk           (clk),
    .rst_n         (rst_sn),
    .load_i        (cfg_load_i),
    .ld_dec_i      (ld_dec),
    .ld_dir_i      (cfg_dir_i),
    .ld_cnt_zero_i (cnt_zero),
    .req_lvl_i     (req_lvl),
    .req_rise_i    (req_rise),
    .ack_i         (ack_i),
    .slave_acc_i   (slave_acc_i),
    .last_i        (last),
    .step_o        (step),
    .bus_act_o     (bus_act),
    .rd_n_o        (rd_n_o),
    .wr_n_o        (wr_n_o),
    .grant_n_o     (grant_n_o),
    .busy_o        (busy_o),
    .done_o        (done_irq_o),
    .cfg_err_o     (cfg_err_o)
  );

  assign addr_o = bus_act ? index : '0;

  AST_STRB_EXCL: assert property (@(posedge clk) disable iff (!rst_sn)
    !(!rd_n_o && !wr_n_o)); // R3

  AST_ADDR_QUIET: assert property (@(posedge clk) disable iff (!rst_sn)
    (rd_n_o && wr_n_o) |-> (addr_o == '0)); // R2

endmodule

// File: tb/tb_ext_dma_channel.sv
module tb_ext_dma_channel;

  localparam int AW = 16;
  localparam int CW = 16;

  typedef struct packed {
    logic [1:0]    kind;
    logic [AW-1:0] addr;
  } exp_t;

  localparam logic [1:0] K_RD  = 2'd0;
  localparam logic [1:0] K_WR  = 2'd1;
  localparam logic [1:0] K_GNT = 2'd2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_load;
  logic [2:0]    cfg_mode;
  logic          cfg_dir;
  logic [AW-1:0] cfg_index, cfg_modify;
  logic [CW-1:0] cfg_count;
  logic          req_n, ack, slave_acc;
  logic [AW-1:0] addr;
  logic          rd_n, wr_n, grant_n, busy, done_irq, cfg_err;

  int   n_chk = 0;
  int   n_fail = 0;
  int   done_seen = 0;
  int   ack_mode = 0;
  bit   finished = 1'b0;
  logic gnt_prev = 1'b0;
  exp_t sb_q[$];

  always #10 clk = ~clk;

  ext_dma_channel #(.AW(AW), .CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_load_i(cfg_load), .cfg_mode_i(cfg_mode),
    .cfg_dir_i(cfg_dir), .cfg_index_i(cfg_index), .cfg_modify_i(cfg_modify),
    .cfg_count_i(cfg_count), .req_n_i(req_n), .ack_i(ack), .slave_acc_i(slave_acc),
    .addr_o(addr), .rd_n_o(rd_n), .wr_n_o(wr_n), .grant_n_o(grant_n),
    .busy_o(busy), .done_irq_o(done_irq), .cfg_err_o(cfg_err)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // ack driver: 0 = held high, 1 = alternating, 2 = held low
  initial begin
    ack = 1'b0;
    forever begin
      @(negedge clk);
      if (ack_mode == 0)      ack = 1'b1;
      else if (ack_mode == 1) ack = ~ack;
      else                    ack = 1'b0;
    end
  end

  // monitor: samples shortly after the falling edge, each sample describes the next rising edge
  initial begin
    forever begin
      exp_t e;
      @(negedge clk);
      #2;
      if (rst_n) begin
        if (!rd_n && !wr_n) chk(1'b0, "R3 both strobes low", 0, 1);
        if ((!rd_n || !wr_n) && ack) begin
          if (sb_q.size() == 0) chk(1'b0, "R2 unexpected bus transfer", addr, 0);
          else begin
            e = sb_q.pop_front();
            chk(e.kind == (rd_n ? K_WR : K_RD) && e.addr == addr,
                "R8 bus transfer kind/address", {rd_n, addr}, {e.kind, e.addr});
          end
        end
        if (!grant_n) begin
          if (gnt_prev) chk(1'b0, "R5 grant longer than one cycle", 2, 1);
          if (sb_q.size() == 0) chk(1'b0, "R5 unexpected grant", 1, 0);
          else begin
            e = sb_q.pop_front();
            chk(e.kind == K_GNT, "R6 grant order", K_GNT, e.kind);
          end
        end
        gnt_prev = !grant_n;
        if (done_irq) done_seen++;
      end
    end
  end

  task automatic push(input logic [1:0] k, input logic [AW-1:0] a);
    exp_t e;
    e.kind = k;
    e.addr = a;
    sb_q.push_back(e);
  endtask

  task automatic load(input logic [2:0] m, input logic d, input logic [AW-1:0] idx,
                      input logic [AW-1:0] md, input logic [CW-1:0] c);
    @(negedge clk);
    cfg_mode = m; cfg_dir = d; cfg_index = idx; cfg_modify = md; cfg_count = c;
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  task automatic wait_idle(input string tag);
    int n = 0;
    while (busy && n < 400) begin
      @(negedge clk);
      n++;
    end
    repeat (2) @(negedge clk);
    #4;
    chk(!busy, tag, busy, 0);
  endtask

  task automatic req_pulse();
    @(negedge clk); req_n = 1'b0;
    repeat (4) @(negedge clk);
    req_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic end_checks(input string tag, input int d0);
    chk(sb_q.size() == 0, {tag, " all expected transfers seen"}, sb_q.size(), 0);
    chk(done_seen - d0 == 1, {tag, " one done pulse (R9)"}, done_seen - d0, 1);
  endtask

  initial begin
    int d0;
    rst_n = 1'b0; cfg_load = 1'b0; cfg_mode = 3'b000; cfg_dir = 1'b0;
    cfg_index = '0; cfg_modify = '0; cfg_count = '0;
    req_n = 1'b1; slave_acc = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #4;
    // reset state
    chk(rd_n && wr_n && grant_n, "R2 strobes/grant idle after reset", {rd_n, wr_n, grant_n}, 3'b111);
    chk(!busy && !done_irq && addr == 0, "R9 idle after reset", {busy, done_irq}, 0);
    chk(!cfg_err, "R1 no error after reset", cfg_err, 0);

    // R2 R3 R8: master write, alternating ack
    ack_mode = 1;
    d0 = done_seen;
    for (int k = 0; k < 5; k++) push(K_WR, 16'h0100 + 16'(k * 4));
    load(3'b100, 1'b1, 16'h0100, 16'h0004, 16'd5);
    #4;
    chk(!wr_n && rd_n && addr == 16'h0100, "R2 master strobe after load", {wr_n, addr}, 16'h0100);
    wait_idle("R9 master write ends");
    end_checks("R2", d0);

    // R3 R8: master read, negative step, ack held high
    ack_mode = 0;
    d0 = done_seen;
    for (int k = 0; k < 3; k++) push(K_RD, 16'h0010 - 16'(k * 2));
    load(3'b100, 1'b0, 16'h0010, 16'hFFFE, 16'd3);
    wait_idle("R9 master read ends");
    end_checks("R3", d0);

    // R4: paced master waits for request
    d0 = done_seen;
    for (int k = 0; k < 3; k++) push(K_WR, 16'h0040 + 16'(k));
    load(3'b110, 1'b1, 16'h0040, 16'h0001, 16'd3);
    repeat (6) @(negedge clk);
    #4;
    chk(busy && rd_n && wr_n && sb_q.size() == 3, "R4 paced holds without request",
        {busy, rd_n, wr_n}, 3'b111);
    @(negedge clk); req_n = 1'b0;
    wait_idle("R4 paced ends");
    req_n = 1'b1;
    end_checks("R4", d0);
    repeat (4) @(negedge clk);

    // R5: handshake, one grant per request
    d0 = done_seen;
    for (int k = 0; k < 3; k++) push(K_GNT, '0);
    load(3'b010, 1'b0, 16'h0300, 16'h0001, 16'd3);
    req_pulse();
    chk(busy && sb_q.size() == 2, "R5 one grant for first request", sb_q.size(), 2);
    req_pulse();
    req_pulse();
    wait_idle("R5 handshake ends");
    end_checks("R5", d0);

    // R6: external handshake, grant then bus
    d0 = done_seen;
    push(K_GNT, '0); push(K_RD, 16'h0200);
    push(K_GNT, '0); push(K_RD, 16'h0208);
    load(3'b011, 1'b0, 16'h0200, 16'h0008, 16'd2);
    req_pulse();
    chk(sb_q.size() == 2, "R6 grant then read for first request", sb_q.size(), 2);
    req_pulse();
    wait_idle("R6 ext handshake ends");
    end_checks("R6", d0);

    // R7: slave, external accesses count
    d0 = done_seen;
    load(3'b000, 1'b1, 16'h0000, 16'h0001, 16'd3);
    for (int k = 0; k < 2; k++) begin
      @(negedge clk); slave_acc = 1'b1;
      @(negedge clk); slave_acc = 1'b0;
    end
    repeat (2) @(negedge clk);
    #4;
    chk(busy && done_seen == d0, "R7 slave still busy after two accesses", busy, 1);
    @(negedge clk); slave_acc = 1'b1;
    @(negedge clk); slave_acc = 1'b0;
    wait_idle("R7 slave ends");
    end_checks("R7", d0);

    // R1: reserved code
    load(3'b101, 1'b1, 16'h0000, 16'h0001, 16'd4);
    #4;
    chk(cfg_err && !busy, "R1 reserved code idles and flags", {cfg_err, busy}, 2'b10);
    d0 = done_seen;
    push(K_WR, 16'h0777);
    load(3'b100, 1'b1, 16'h0777, 16'h0001, 16'd1);
    wait_idle("R1 legal load after error runs");
    chk(cfg_err, "R1 error flag sticky", cfg_err, 1);
    end_checks("R1", d0);

    // R9: zero count starts nothing
    d0 = done_seen;
    load(3'b100, 1'b1, 16'h0500, 16'h0001, 16'd0);
    repeat (3) @(negedge clk);
    #4;
    chk(!busy && done_seen == d0 && rd_n && wr_n, "R9 zero count idle", {busy, done_seen - d0}, 0);

    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule